// File: doc/BRIEF.md
# Fetch Bounds Checker with Caller Attribution

This block sits in an instruction fetch stage and confirms that each fetched instruction lies entirely inside the bounds of the current program-counter capability. The lower bound is inclusive and the upper bound is exclusive. It works out the instruction length from the low opcode bits. Every instruction is checked, because any advance of the PC can carry it out of bounds, and this includes instructions reached sequentially.

The block also needs to know who caused a fault. It keeps a private record of the last retired instruction's PC, and whether that instruction redirected the flow (a taken jump or branch). If a fault lands on the target of such a transfer, the reported trap address is the address of the jumping instruction and not the faulting fetch address. This lets a fault handler charge the error to the caller. The record is internal and is not an architectural register.

Instructions that pass the check are forwarded with one cycle of latency. A detected fault is latched and held until the pipeline flushes.

Top module: `fetch_bounds_guard`

## Requirements
- R1: After reset, `fault` and `insn_valid` are low and `fault_pc` is zero.
- R2: An instruction whose low two bits are not `11` is compressed and spans 2 bytes. At `fetch_pc = cap_top - 2` it passes the check.
- R3: An instruction whose low two bits are `11` spans 4 bytes. It faults when `fetch_pc + 4 > cap_top`, even when its first two bytes are in bounds.
- R4: A valid fetch with `fetch_pc < cap_base` faults.
- R5: If the last retired instruction did not redirect, a fault records the faulting fetch PC in `fault_pc`.
- R6: If the last retired instruction was retired with `redirect` high, a fault records that instruction's PC in `fault_pc`.
- R7: The previous-PC record and the transfer flag change only on a cycle with `retire` high. A `redirect` without `retire` has no effect on attribution.
- R8: Once raised, `fault` stays high and `fault_pc` stays unchanged until `flush`. Later out-of-bounds fetches do not overwrite it.
- R9: A valid, in-bounds fetch made while no fault is held appears on `insn_valid`/`insn_out` one cycle later. Out-of-bounds fetches and fetches made while a fault is held are not forwarded.
- R10: `flush` clears `fault` on the next cycle, and it takes priority over a new fault in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch PC and instruction bits are valid |
| fetch_pc | input | ADDR_W | Address of the fetched instruction |
| fetch_insn | input | INSN_W | Fetched instruction bits |
| cap_base | input | ADDR_W | Inclusive lower bound of the PC capability |
| cap_top | input | ADDR_W | Exclusive upper bound of the PC capability |
| redirect | input | 1 | The retiring instruction is a taken jump or branch |
| retire | input | 1 | The instruction at `fetch_pc` retires this cycle |
| flush | input | 1 | Acknowledges and clears a held fault |
| fault | output | 1 | Bounds fault held |
| fault_pc | output | ADDR_W | Trap address to record |
| insn_valid | output | 1 | Forwarded instruction is valid |
| insn_out | output | INSN_W | Forwarded instruction bits |

## Verification
The bench focuses on a 4-byte instruction placed two bytes below the top bound. A checker that measured only two bytes would forward this instruction instead of faulting. The bench also faults a transfer target and expects the jump's address: a design that used the wrong attribution would report the target PC instead. It issues a redirect without a retire, where a tracker that ignores `retire` would wrongly blame a caller. It sends fresh out-of-bounds fetches while a fault is held, where a non-sticky fault register would let `fault_pc` drift.

// File: rtl/fbg_pkg.sv
// Shared types for the fetch bounds checker.
// Assumes instruction length is 2 or 4 bytes, chosen by the two low opcode bits.
package fbg_pkg;
    typedef enum logic {
        LEN_HALF = 1'b0,
        LEN_WORD = 1'b1
    } len_class_e;

    localparam logic [1:0] WORD_OPC_LOW = 2'b11;
endpackage

// File: rtl/fbg_len_decode.sv
// Length decoder: classifies an instruction as 2 or 4 bytes long and gives its
// byte span. Assumes only the two low bits carry the length.
module fbg_len_decode #(
    parameter int INSN_W = 32,
    parameter int SPAN_W = 3
) (
    input  logic [INSN_W-1:0]   insn,
    output fbg_pkg::len_class_e len_class,
    output logic [SPAN_W-1:0]   span
);
    // Pick length class from the low opcode bits.
    always_comb begin
        if (insn[1:0] == fbg_pkg::WORD_OPC_LOW) begin
            len_class = fbg_pkg::LEN_WORD;
            span      = SPAN_W'(4);
        end else begin
            len_class = fbg_pkg::LEN_HALF;
            span      = SPAN_W'(2);
        end
    end
endmodule

// File: rtl/fbg_range_cmp.sv
// Range comparator: flags an instruction whose span [pc, pc+span) leaves
// [base, top). Uses one extra bit so pc+span cannot wrap.
module fbg_range_cmp #(
    parameter int ADDR_W = 32,
    parameter int SPAN_W = 3
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [SPAN_W-1:0] span,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] top,
    output logic              out_of_bounds
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] end_addr;

    // Exclusive end address of the instruction, widened against wrap.
    always_comb end_addr = {1'b0, pc} + EXT_W'(span);

    // Compare both edges of the span against the bounds.
    always_comb out_of_bounds = (pc < base) || (end_addr > {1'b0, top});
endmodule

// File: rtl/fbg_caller_track.sv
// Caller tracker: private record of the last retired PC and whether that
// instruction redirected the flow. It updates only on retire.
module fbg_caller_track #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] prev_pc,
    output logic              from_xfer
);
    // Capture the retiring PC and its transfer flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_pc   <= '0;
            from_xfer <= 1'b0;
        end else if (retire) begin
            prev_pc   <= pc;
            from_xfer <= redirect;
        end
    end
endmodule

// File: rtl/fetch_bounds_guard.sv
// Fetch bounds checker with caller attribution. It checks each fetched
// instruction over its full length against the PC capability bounds. It latches
// a fault until flush, charging a fault on a transfer target to the instruction
// that jumped. In-bounds instructions are forwarded one cycle later.
// Assumes retire refers to the instruction currently on fetch_pc.
module fetch_bounds_guard #(
    parameter int ADDR_W = 32,
    parameter int INSN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [INSN_W-1:0] fetch_insn,
    input  logic [ADDR_W-1:0] cap_base,
    input  logic [ADDR_W-1:0] cap_top,
    input  logic              redirect,
    input  logic              retire,
    input  logic              flush,
    output logic              fault,
    output logic [ADDR_W-1:0] fault_pc,
    output logic              insn_valid,
    output logic [INSN_W-1:0] insn_out
);
    localparam int SPAN_W = 3;

    fbg_pkg::len_class_e len_class;
    logic [SPAN_W-1:0]   span;
    logic                oob;
    logic [ADDR_W-1:0]   prev_pc;
    logic                from_xfer;
    logic                new_fault;
    logic [ADDR_W-1:0]   blame_pc;
    logic                fault_q;
    logic [ADDR_W-1:0]   fault_pc_q;
    logic                pass_q;
    logic [INSN_W-1:0]   insn_q;

    fbg_len_decode #(.INSN_W(INSN_W), .SPAN_W(SPAN_W)) u_len (
        .insn      (fetch_insn),
        .len_class (len_class),
        .span      (span)
    );

    fbg_range_cmp #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W)) u_cmp (
        .pc            (fetch_pc),
        .span          (span),
        .base          (cap_base),
        .top           (cap_top),
        .out_of_bounds (oob)
    );

    fbg_caller_track #(.ADDR_W(ADDR_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .retire    (retire),
        .redirect  (redirect),
        .pc        (fetch_pc),
        .prev_pc   (prev_pc),
        .from_xfer (from_xfer)
    );

    // A new fault needs a valid out-of-bounds fetch while none is held.
    always_comb new_fault = fetch_valid && oob && !fault_q;

    // Blame the jumping instruction for transfer targets, else the fetch itself.
    always_comb blame_pc = from_xfer ? prev_pc : fetch_pc;

    // Sticky fault register, cleared only by flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q    <= 1'b0;
            fault_pc_q <= '0;
        end else if (flush) begin
            fault_q    <= 1'b0;
        end else if (new_fault) begin
            fault_q    <= 1'b1;
            fault_pc_q <= blame_pc;
        end
    end

    // Forward in-bounds instructions with one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
            insn_q <= '0;
        end else begin
            pass_q <= fetch_valid && !oob && !fault_q;
            if (fetch_valid && !oob && !fault_q) insn_q <= fetch_insn;
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        fault      = fault_q;
        fault_pc   = fault_pc_q;
        insn_valid = pass_q;
        insn_out   = insn_q;
    end
endmodule

// File: rtl/fetch_bounds_guard_chk.sv
// Property checker for fetch_bounds_guard, bound to every instance.
module fetch_bounds_guard_chk #(
    parameter int ADDR_W = 32,
    parameter int INSN_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic [INSN_W-1:0] fetch_insn,
    input logic [ADDR_W-1:0] cap_base,
    input logic [ADDR_W-1:0] cap_top,
    input logic              flush,
    input logic              fault,
    input logic [ADDR_W-1:0] fault_pc,
    input logic              insn_valid
);
    // R8
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault && !flush |=> fault && $stable(fault_pc));

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !fault);

    // R9
    no_pass_faulted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !insn_valid);

    // R4
    below_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && (fetch_pc < cap_base) && !flush |=> fault);

    // R3
    word_over_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && (fetch_insn[1:0] == 2'b11) && (fetch_pc == cap_top - 2)
        && (fetch_pc >= cap_base) && !flush |=> fault);
endmodule

bind fetch_bounds_guard fetch_bounds_guard_chk #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .fetch_insn  (fetch_insn),
    .cap_base    (cap_base),
    .cap_top     (cap_top),
    .flush       (flush),
    .fault       (fault),
    .fault_pc    (fault_pc),
    .insn_valid  (insn_valid)
);

// File: tb/fetch_bounds_guard_tb.sv
module fetch_bounds_guard_tb;
    localparam int AW = 32;
    localparam int IW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fetch_valid, redirect, retire, flush;
    logic [AW-1:0] fetch_pc, cap_base, cap_top;
    logic [IW-1:0] fetch_insn;
    logic          fault, insn_valid;
    logic [AW-1:0] fault_pc;
    logic [IW-1:0] insn_out;

    int n_chk = 0;
    int n_bad = 0;

    // bench model state
    logic          m_fault, m_valid, m_xfer;
    logic [AW-1:0] m_fpc, m_prev;
    logic [IW-1:0] m_insn;

    always #2 clk = ~clk;

    fetch_bounds_guard #(.ADDR_W(AW), .INSN_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_insn(fetch_insn), .cap_base(cap_base), .cap_top(cap_top),
        .redirect(redirect), .retire(retire), .flush(flush), .fault(fault),
        .fault_pc(fault_pc), .insn_valid(insn_valid), .insn_out(insn_out)
    );

    function automatic logic exp_oob(logic [AW-1:0] pc, logic [IW-1:0] insn,
                                     logic [AW-1:0] b, logic [AW-1:0] t);
        longint unsigned len = (insn[1:0] == 2'b11) ? 4 : 2;
        return (pc < b) || (longint'(pc) + len > longint'(t));
    endfunction

    task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: update model from the current inputs, then compare after the edge.
    task automatic step(string tag);
        logic oob = fetch_valid && exp_oob(fetch_pc, fetch_insn, cap_base, cap_top);
        logic          nf = m_fault;
        logic [AW-1:0] nfpc = m_fpc;
        logic          nv = fetch_valid && !oob && !m_fault;
        logic [IW-1:0] ni = nv ? fetch_insn : m_insn;
        if (flush) nf = 1'b0;
        else if (!m_fault && oob) begin
            nf = 1'b1;
            nfpc = m_xfer ? m_prev : fetch_pc;
        end
        if (retire) begin
            m_prev = fetch_pc;
            m_xfer = redirect;
        end
        m_fault = nf; m_fpc = nfpc; m_valid = nv; m_insn = ni;
        @(posedge clk);
        @(negedge clk);
        check({tag, " fault"}, AW'(fault), AW'(m_fault));
        check({tag, " fault_pc"}, fault_pc, m_fpc);
        check({tag, " insn_valid"}, AW'(insn_valid), AW'(m_valid));
        if (m_valid) check({tag, " insn_out"}, insn_out, m_insn);
    endtask

    task automatic drive(logic v, logic [AW-1:0] pc, logic [IW-1:0] insn,
                         logic rd, logic rt, logic fl);
        fetch_valid = v; fetch_pc = pc; fetch_insn = insn;
        redirect = rd; retire = rt; flush = fl;
    endtask

    initial begin
        fork
            begin
                void'($urandom(32'd7151));
                rst_n = 1'b0;
                cap_base = 32'h1000; cap_top = 32'h1100;
                drive(0, 0, 0, 0, 0, 0);
                m_fault = 0; m_valid = 0; m_xfer = 0; m_fpc = 0; m_prev = 0; m_insn = 0;
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                // R1 reset state
                check("R1 fault", AW'(fault), '0);
                check("R1 fault_pc", fault_pc, '0);
                check("R1 insn_valid", AW'(insn_valid), '0);

                // R2 compressed at top-2 passes
                drive(1, 32'h10FE, 32'h0000_4501, 0, 1, 0); step("R2");
                check("R2 passed", AW'(insn_valid), 1);
                // R3 word at top-2 faults; R5 own PC since last retire was sequential
                drive(1, 32'h10FE, 32'h0000_0013, 0, 0, 0); step("R3");
                check("R3 fault", AW'(fault), 1);
                check("R5 own pc", fault_pc, 32'h10FE);
                // R8 later fault does not overwrite
                drive(1, 32'h0F00, 32'h0000_0013, 0, 0, 0); step("R8");
                check("R8 held pc", fault_pc, 32'h10FE);
                // R10 flush with a bad fetch in the same cycle
                drive(1, 32'h0F00, 32'h0000_0013, 0, 0, 1); step("R10");
                check("R10 cleared", AW'(fault), 0);
                // R6 jump at 0x1040 retires with redirect, target below base
                drive(1, 32'h1040, 32'h0000_006F, 1, 1, 0); step("R6 jump");
                drive(1, 32'h0FF0, 32'h0000_0013, 0, 0, 0); step("R6");
                check("R6 caller pc", fault_pc, 32'h1040);
                drive(0, 0, 0, 0, 0, 1); step("R10 flush");
                // R7 redirect without retire does not mark a transfer
                drive(1, 32'h1010, 32'h0000_0013, 0, 1, 0); step("R7 seq");
                drive(1, 32'h1020, 32'h0000_006F, 1, 0, 0); step("R7 noretire");
                drive(1, 32'h0FFE, 32'h0000_4501, 0, 0, 0); step("R4");
                check("R7 own pc", fault_pc, 32'h0FFE);
                check("R4 fault", AW'(fault), 1);
                drive(0, 0, 0, 0, 0, 1); step("R10 flush");

                // R9 and the rest: constrained random traffic
                for (int i = 0; i < 3000; i++) begin
                    logic [AW-1:0] pc = (32'h0FF8 + ($urandom % 32'h110)) & ~32'h1;
                    logic [IW-1:0] in = $urandom;
                    drive(($urandom % 4) != 0, pc, in, $urandom % 2,
                          ($urandom % 3) == 0, ($urandom % 5) == 0);
                    step("R9 random");
                end
            end
            begin
                repeat (200000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule